// File: doc/BRIEF.md
# Banked DRAM Access Arbiter

This block sits between a processor bus and a four-bank DRAM array. It decides whether the array serves a processor access or a refresh cycle, and it drives the row strobe enable and column strobe enable for each bank. Every bank has its own precharge timer. An access to a bank other than the one just closed can therefore start on the next clock edge. A repeat access to the same bank waits until that bank's precharge time has passed. A refresh raises all four row strobes together for a programmed number of cycles. After the refresh, every bank waits out a full precharge.

An access starts when the address strobe and chip select are both high on a rising clock edge. In the latched start mode, that edge only records the request, and the row strobe rises one edge later. In the immediate start mode, the row strobe rises on that same edge. If the target bank is still precharging, or a refresh is pending or running, the request is held. It is then granted on the first edge at which it is allowed. Bank select bits 1:0 pick exactly one row/column strobe pair: bank value k drives index k. The processor is told when the access is complete through one acknowledge pin. A configuration bit sets whether that pin behaves as an active-low wait line or as an active-high transfer acknowledge. All outputs come from registers, and all configuration inputs are static levels. The bus handshake itself stays plain, with no valid/ready pairing, because no data passes through the block.

Top module: `dram_bank_arbiter`

## Requirements
- R1: While reset is held and after it is released with no request, all row and column enables are 0, and `wait_ack` is 1 when `cfg_ack_mode`=0 and 0 when `cfg_ack_mode`=1. A strobe without chip select starts nothing.
- R2: With `cfg_immediate`=0, a strobe and chip select sampled on edge k raise `ras_en[bank_sel]` after edge k+1 when the bank is free. After edge k it is still low.
- R3: With `cfg_immediate`=1, a strobe and chip select sampled on edge k raise `ras_en[bank_sel]` after edge k when the bank is free.
- R4: The acknowledge comes 1 cycle after the row strobe rises. If `wait_inc_n` is low on the granting edge, it comes 1 cycle later, or 2 cycles later when `cfg_wait_double`=1.
- R5: In wait mode (`cfg_ack_mode`=0), `wait_ack` is low while a request is held or an access is not yet acknowledged, and high otherwise. In acknowledge mode (`cfg_ack_mode`=1), `wait_ack` is high only while an access is acknowledged.
- R6: An access ends on the first edge at which it is acknowledged and `acc_req` is low. If `acc_req` goes low before the acknowledge, the row strobe stays high until the acknowledge cycle.
- R7: Precharge N is 1, 2, 2, 3 cycles for `cfg_pre_code` 00, 01, 10, 11. After an access ends, a held request to the same bank sees N cycles of all-low row strobes before its grant. A held request to a different bank sees exactly 1 cycle.
- R8: A refresh raises all four row enables together for L cycles: L is 2, 3, 2, 4 for `cfg_pre_code` 00, 01, 10, 11. It is granted one edge after `refresh_req` is sampled high when the array is idle and precharged.
- R9: A refresh requested during an access is granted only after that access ends and every bank has precharged. A request held during the refresh is granted only after the refresh ends and precharge N passes.
- R10: `cas_en[bank]` rises one cycle after the row strobe. With `cfg_cas_extend`=0 it falls together with the row strobe. With `cfg_cas_extend`=1 and `byte_en[bank]` high at the end, it stays high until `byte_en[bank]` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_immediate | input | 1 | 1: immediate start, 0: latched start |
| cfg_pre_code | input | 2 | Precharge and refresh length code |
| cfg_ack_mode | input | 1 | 0: active-low wait, 1: transfer acknowledge |
| cfg_wait_double | input | 1 | Extra wait length when `wait_inc_n` is low (0: 1 cycle, 1: 2 cycles) |
| cfg_cas_extend | input | 1 | Column strobe may outlast the row strobe |
| adr_strobe | input | 1 | Address strobe, starts an access |
| chip_sel | input | 1 | Chip select, qualifies the strobe |
| acc_req | input | 1 | Access request; low ends the access |
| bank_sel | input | 2 | Bank number, sampled with the strobe |
| byte_en | input | 4 | Byte enables that hold the column strobes |
| wait_inc_n | input | 1 | Low adds wait cycles to the access being granted |
| refresh_req | input | 1 | Refresh request |
| ras_en | output | 4 | Row strobe enables, one per bank |
| cas_en | output | 4 | Column strobe enables, one per bank |
| wait_ack | output | 1 | Wait or acknowledge output |

## Verification
A wrong precharge counter shows up on the very next access to that bank: the run of all-low row strobes before the grant is one or more cycles too short or too long. A lost or doubled held request shows within a few cycles, either as a row strobe on the wrong bank or as no row strobe at all after an access ends. A wrong acknowledge count shows on `wait_ack` in the cycles just after the row strobe rises. A refresh held back too long, or granted too early, moves the all-banks-high window relative to the end of the previous access, so its start cycle and length expose the fault at once.

// File: rtl/dab_pkg.sv
package dab_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACC  = 2'd1,
    SEQ_REF  = 2'd2
  } seq_e;

  // precharge length in clock cycles for each code
  function automatic logic [2:0] pre_edges(input logic [1:0] code);
    case (code)
      2'b00:   pre_edges = 3'd1;
      2'b11:   pre_edges = 3'd3;
      default: pre_edges = 3'd2;
    endcase
  endfunction

  // row strobe length during refresh for each code
  function automatic logic [2:0] ref_edges(input logic [1:0] code);
    case (code)
      2'b01:   ref_edges = 3'd3;
      2'b11:   ref_edges = 3'd4;
      default: ref_edges = 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/dab_bank_timer.sv
module dab_bank_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          ready_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= load_val_i;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign ready_o = (cnt == '0);
endmodule

// File: rtl/dab_sequencer.sv
module dab_sequencer
  import dab_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_imm_i,
  input  logic             cfg_dbl_i,
  input  logic [1:0]       cfg_pre_code_i,
  input  logic             strobe_i,
  input  logic             cs_i,
  input  logic             areq_i,
  input  logic [BW-1:0]    bank_i,
  input  logic             wait_inc_n_i,
  input  logic             refresh_req_i,
  input  logic [NBANK-1:0] bank_ready_i,
  output seq_e             state_o,
  output logic [BW-1:0]    cur_bank_o,
  output logic             ack_o,
  output logic             pend_o,
  output logic             cas_phase_o,
  output logic             end_acc_o,
  output logic             end_ref_o
);
  seq_e          state;
  logic          pend, ref_pend;
  logic [BW-1:0] pend_bank, cur_bank, src_bank;
  logic [1:0]    acnt, extra;
  logic [2:0]    rcnt, ref_len;
  logic          hit, acc_req, idle, grant_ref, grant_acc, ack, end_acc, end_ref, take_hit;

  always_comb begin
    ref_len   = ref_edges(cfg_pre_code_i);
    hit       = strobe_i & cs_i;
    src_bank  = pend ? pend_bank : bank_i;
    acc_req   = pend | (cfg_imm_i & hit);
    idle      = (state == SEQ_IDLE);
    grant_ref = idle & ref_pend & (&bank_ready_i);
    grant_acc = idle & ~ref_pend & acc_req & bank_ready_i[src_bank];
    ack       = (state == SEQ_ACC) & (3'(acnt) >= (3'd1 + 3'(extra)));
    end_acc   = ack & ~areq_i;
    end_ref   = (state == SEQ_REF) & (rcnt == ref_len - 3'd1);
    // a strobe is held unless it is granted directly or a held one is kept
    take_hit  = hit & (~pend | grant_acc) & ~(cfg_imm_i & ~pend & grant_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      pend      <= 1'b0;
      pend_bank <= '0;
      ref_pend  <= 1'b0;
      cur_bank  <= '0;
      acnt      <= '0;
      extra     <= '0;
      rcnt      <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (grant_ref) begin
            state <= SEQ_REF;
            rcnt  <= '0;
          end else if (grant_acc) begin
            state    <= SEQ_ACC;
            cur_bank <= src_bank;
            acnt     <= '0;
            extra    <= wait_inc_n_i ? 2'd0 : (cfg_dbl_i ? 2'd2 : 2'd1);
          end
        end
        SEQ_ACC: begin
          if (end_acc)          state <= SEQ_IDLE;
          if (acnt != 2'd3)     acnt  <= acnt + 2'd1;
        end
        SEQ_REF: begin
          if (end_ref) state <= SEQ_IDLE;
          rcnt <= rcnt + 3'd1;
        end
        default: state <= SEQ_IDLE;
      endcase

      if (grant_ref)          ref_pend <= 1'b0;
      else if (refresh_req_i) ref_pend <= 1'b1;

      if (take_hit) begin
        pend      <= 1'b1;
        pend_bank <= bank_i;
      end else if (grant_acc) begin
        pend <= 1'b0;
      end
    end
  end

  assign state_o     = state;
  assign cur_bank_o  = cur_bank;
  assign ack_o       = ack;
  assign pend_o      = pend;
  assign cas_phase_o = (state == SEQ_ACC) & (acnt != 2'd0);
  assign end_acc_o   = end_acc;
  assign end_ref_o   = end_ref;
endmodule

// File: rtl/dab_pin_drive.sv
module dab_pin_drive
  import dab_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_e             state_i,
  input  logic [BW-1:0]    cur_bank_i,
  input  logic             cas_phase_i,
  input  logic             ack_i,
  input  logic             pend_i,
  input  logic             end_acc_i,
  input  logic             cfg_cas_ext_i,
  input  logic             cfg_ack_mode_i,
  input  logic [NBANK-1:0] byte_en_i,
  output logic [NBANK-1:0] ras_o,
  output logic [NBANK-1:0] cas_o,
  output logic             wait_o
);
  logic in_acc, in_ref, stalled;

  assign in_acc = (state_i == SEQ_ACC);
  assign in_ref = (state_i == SEQ_REF);

  for (genvar g = 0; g < NBANK; g++) begin : g_pin
    logic sel, hold;
    assign sel = (cur_bank_i == BW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          hold <= 1'b0;
      else if (end_acc_i && sel && cfg_cas_ext_i && byte_en_i[g]) hold <= 1'b1;
      else if (!byte_en_i[g])                              hold <= 1'b0;
    end

    assign ras_o[g] = (in_acc && sel) || in_ref;
    assign cas_o[g] = (cas_phase_i && sel) || hold;
  end

  assign stalled = (pend_i | in_acc) & ~ack_i;
  assign wait_o  = cfg_ack_mode_i ? ack_i : ~stalled;
endmodule

// File: rtl/dram_bank_arbiter.sv
module dram_bank_arbiter
  import dab_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_immediate,
  input  logic [1:0]       cfg_pre_code,
  input  logic             cfg_ack_mode,
  input  logic             cfg_wait_double,
  input  logic             cfg_cas_extend,
  input  logic             adr_strobe,
  input  logic             chip_sel,
  input  logic             acc_req,
  input  logic [1:0]       bank_sel,
  input  logic [NBANK-1:0] byte_en,
  input  logic             wait_inc_n,
  input  logic             refresh_req,
  output logic [NBANK-1:0] ras_en,
  output logic [NBANK-1:0] cas_en,
  output logic             wait_ack
);
  localparam int BW = 2;
  localparam int PW = 3;

  seq_e             state;
  logic [BW-1:0]    cur_bank;
  logic             ack, pend, cas_phase, end_acc, end_ref;
  logic [NBANK-1:0] bank_ready;
  logic [PW-1:0]    pre_load;

  assign pre_load = pre_edges(cfg_pre_code) - 3'd1;

  dab_sequencer #(.NBANK(NBANK), .BW(BW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_imm_i     (cfg_immediate),
    .cfg_dbl_i     (cfg_wait_double),
    .cfg_pre_code_i(cfg_pre_code),
    .strobe_i      (adr_strobe),
    .cs_i          (chip_sel),
    .areq_i        (acc_req),
    .bank_i        (bank_sel),
    .wait_inc_n_i  (wait_inc_n),
    .refresh_req_i (refresh_req),
    .bank_ready_i  (bank_ready),
    .state_o       (state),
    .cur_bank_o    (cur_bank),
    .ack_o         (ack),
    .pend_o        (pend),
    .cas_phase_o   (cas_phase),
    .end_acc_o     (end_acc),
    .end_ref_o     (end_ref)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic ld;
    assign ld = (end_acc && (cur_bank == BW'(g))) || end_ref;
    dab_bank_timer #(.CW(PW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ld),
      .load_val_i(pre_load),
      .ready_o   (bank_ready[g])
    );
  end

  dab_pin_drive #(.NBANK(NBANK), .BW(BW)) u_pin (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state),
    .cur_bank_i    (cur_bank),
    .cas_phase_i   (cas_phase),
    .ack_i         (ack),
    .pend_i        (pend),
    .end_acc_i     (end_acc),
    .cfg_cas_ext_i (cfg_cas_extend),
    .cfg_ack_mode_i(cfg_ack_mode),
    .byte_en_i     (byte_en),
    .ras_o         (ras_en),
    .cas_o         (cas_en),
    .wait_o        (wait_ack)
  );
endmodule

// File: rtl/dab_checker.sv
module dab_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_pre_code,
  input logic             cfg_ack_mode,
  input logic             acc_req,
  input logic [NBANK-1:0] byte_en,
  input logic [NBANK-1:0] ras_en,
  input logic [NBANK-1:0] cas_en,
  input logic             wait_ack
);
  // R8: either one bank is open or all banks refresh together
  assert_ras_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(ras_en) || (&ras_en)));

  // R6: an access row strobe with the request held does not move
  assert_access_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot(ras_en) && acc_req) |=> (ras_en == $past(ras_en)));

  // R10: a column strobe beyond its row strobe needs its byte enable
  assert_cas_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cas_en & ~ras_en & ~$past(byte_en)) == '0));

  // R5: acknowledge mode only reports completion during an open access
  assert_ack_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ack_mode && wait_ack) |-> $onehot(ras_en));

  // R7: with the longest precharge a closed bank stays closed one more cycle
  for (genvar g = 0; g < NBANK; g++) begin : g_pre
    assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_en[g]) && cfg_pre_code == 2'b11) |=> !ras_en[g]);
  end
endmodule

bind dram_bank_arbiter dab_checker #(.NBANK(NBANK)) u_dab_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_pre_code(cfg_pre_code),
  .cfg_ack_mode(cfg_ack_mode),
  .acc_req     (acc_req),
  .byte_en     (byte_en),
  .ras_en      (ras_en),
  .cas_en      (cas_en),
  .wait_ack    (wait_ack)
);

// File: tb/tb_dram_bank_arbiter.sv
`timescale 1ns/100ps
module tb_dram_bank_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_immediate = 0, cfg_ack_mode = 0, cfg_wait_double = 0, cfg_cas_extend = 0;
  logic [1:0] cfg_pre_code = 0;
  logic       adr_strobe = 0, chip_sel = 0, acc_req = 0, wait_inc_n = 1, refresh_req = 0;
  logic [1:0] bank_sel = 0;
  logic [3:0] byte_en = 0;
  logic [3:0] ras_en, cas_en;
  logic       wait_ack;
  int vectors = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dram_bank_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cfg_immediate(cfg_immediate), .cfg_pre_code(cfg_pre_code),
    .cfg_ack_mode(cfg_ack_mode), .cfg_wait_double(cfg_wait_double), .cfg_cas_extend(cfg_cas_extend),
    .adr_strobe(adr_strobe), .chip_sel(chip_sel), .acc_req(acc_req), .bank_sel(bank_sel),
    .byte_en(byte_en), .wait_inc_n(wait_inc_n), .refresh_req(refresh_req),
    .ras_en(ras_en), .cas_en(cas_en), .wait_ack(wait_ack));

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pre_len(input int code);
    return (code == 0) ? 1 : (code == 3) ? 3 : 2;
  endfunction
  function automatic int ref_len(input int code);
    return (code == 1) ? 3 : (code == 3) ? 4 : 2;
  endfunction

  task automatic count_val(input logic [3:0] v, output int n);
    n = 0;
    while (ras_en == v && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // two accesses: the second is held while the first is open
  task automatic gap_test(input int imm, input int code, input int b1, input int b2);
    int n;
    cfg_immediate = imm[0]; cfg_pre_code = code[1:0]; cfg_ack_mode = 1;
    @(negedge clk); adr_strobe = 1; chip_sel = 1; bank_sel = b1[1:0]; acc_req = 1;
    @(negedge clk); adr_strobe = 0;
    if (imm != 0) check("R3 immediate start", ras_en, 1 << b1);
    else          check("R2 latched start not yet", ras_en, 0);
    if (imm == 0) begin
      @(negedge clk);
      check("R2 latched start", ras_en, 1 << b1);
    end
    @(negedge clk);
    check("R4 ack one cycle after row strobe", wait_ack, 1);
    adr_strobe = 1; bank_sel = b2[1:0]; acc_req = 0;
    @(negedge clk); adr_strobe = 0; acc_req = 1;
    count_val(4'h0, n);
    check("R7 precharge gap", n, (b1 == b2) ? pre_len(code) : 1);
    check("R7 held bank granted", ras_en, 1 << b2);
    @(negedge clk); acc_req = 0;
    @(negedge clk); acc_req = 1;
    check("R6 access closed", ras_en, 0);
    settle();
  endtask

  task automatic ack_test(input int mode, input int wi_n, input int dbl);
    int n, extra;
    cfg_immediate = 1; cfg_pre_code = 0; cfg_ack_mode = mode[0]; cfg_wait_double = dbl[0];
    extra = (wi_n != 0) ? 0 : (dbl != 0 ? 2 : 1);
    @(negedge clk); adr_strobe = 1; chip_sel = 1; bank_sel = 2; acc_req = 1; wait_inc_n = wi_n[0];
    @(negedge clk); adr_strobe = 0; wait_inc_n = 1;
    check("R5 stall level at row strobe", wait_ack, 0);
    n = 0;
    while (wait_ack == 0 && n < 10) begin n++; @(negedge clk); end
    check("R4 acknowledge delay", n, 1 + extra);
    check("R5 completion level", wait_ack, 1);
    acc_req = 0;
    @(negedge clk); acc_req = 1;
    check("R6 end after ack", ras_en, 0);
    check("R5 idle level", wait_ack, (mode != 0) ? 0 : 1);
    settle();
  endtask

  task automatic cas_test(input int ext, input int be_hi);
    cfg_immediate = 1; cfg_pre_code = 0; cfg_cas_extend = ext[0];
    byte_en = (be_hi != 0) ? 4'b0010 : 4'b0000;
    @(negedge clk); adr_strobe = 1; chip_sel = 1; bank_sel = 1; acc_req = 1;
    @(negedge clk); adr_strobe = 0;
    check("R10 column strobe lags row strobe", cas_en, 0);
    @(negedge clk);
    check("R10 column strobe on", cas_en, 4'b0010);
    acc_req = 0;
    @(negedge clk); acc_req = 1;
    check("R10 row strobe off", ras_en, 0);
    check("R10 column strobe at end", cas_en, (ext != 0 && be_hi != 0) ? 2 : 0);
    if (ext != 0 && be_hi != 0) begin
      @(negedge clk);
      check("R10 column strobe held", cas_en, 2);
      byte_en = 0;
      @(negedge clk);
      check("R10 column strobe released", cas_en, 0);
    end
    cfg_cas_extend = 0;
    settle();
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset row", ras_en, 0);
    check("R1 reset column", cas_en, 0);
    check("R1 reset wait level", wait_ack, 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle row", ras_en, 0);
    cfg_ack_mode = 1;
    @(negedge clk);
    check("R1 idle acknowledge level", wait_ack, 0);

    // R1: strobe without chip select
    cfg_immediate = 1;
    adr_strobe = 1; chip_sel = 0; bank_sel = 0; acc_req = 1;
    @(negedge clk); adr_strobe = 0;
    repeat (3) begin
      check("R1 no chip select", ras_en, 0);
      @(negedge clk);
    end
    settle();

    // R2 R3 R7: sweep of start mode, code and bank pair
    for (int imm = 0; imm < 2; imm++)
      for (int code = 0; code < 4; code++)
        for (int b1 = 0; b1 < 4; b1++)
          for (int b2 = 0; b2 < 4; b2++)
            gap_test(imm, code, b1, b2);

    // R4 R5
    for (int m = 0; m < 2; m++) begin
      ack_test(m, 1, 0);
      ack_test(m, 0, 0);
      ack_test(m, 0, 1);
    end

    // R6: request dropped before acknowledge
    cfg_immediate = 1; cfg_pre_code = 0; cfg_wait_double = 1;
    @(negedge clk); adr_strobe = 1; chip_sel = 1; bank_sel = 3; acc_req = 0; wait_inc_n = 0;
    @(negedge clk); adr_strobe = 0; wait_inc_n = 1;
    count_val(4'b1000, n);
    check("R6 row strobe held until ack", n, 4);
    settle();
    acc_req = 1;

    // R8: refresh length per code
    for (int code = 0; code < 4; code++) begin
      cfg_pre_code = code[1:0];
      @(negedge clk); refresh_req = 1;
      @(negedge clk); refresh_req = 0;
      count_val(4'h0, n);
      check("R8 refresh grant delay", n, 1);
      count_val(4'hF, n);
      check("R8 refresh length", n, ref_len(code));
      settle();
    end

    // R9: refresh arriving during an access, access held during refresh
    cfg_immediate = 1; cfg_pre_code = 3; cfg_ack_mode = 1;
    @(negedge clk); adr_strobe = 1; chip_sel = 1; bank_sel = 0; acc_req = 1;
    @(negedge clk); adr_strobe = 0; refresh_req = 1;
    @(negedge clk); refresh_req = 0; adr_strobe = 1; bank_sel = 1;
    @(negedge clk); adr_strobe = 0; acc_req = 0;
    @(negedge clk); acc_req = 1;
    count_val(4'h0, n);
    check("R9 refresh waits for precharge", n, 3);
    count_val(4'hF, n);
    check("R9 refresh length", n, 4);
    count_val(4'h0, n);
    check("R9 held access waits for precharge", n, 3);
    check("R9 held access bank", ras_en, 2);
    @(negedge clk); acc_req = 0;
    @(negedge clk); acc_req = 1;
    settle();

    // R10
    cas_test(0, 1);
    cas_test(1, 1);
    cas_test(1, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule